// File: doc/BRIEF.md
# Debug Breakpoint and Execution Controller

This block sits beside a small CPU core and decides when that core may run. It watches the instruction-boundary program counter and a single memory access bus that carries reads and writes to four address spaces. When a programmed breakpoint slot matches, it halts the core. Spaces are coded 0 for program memory, 1 for internal data memory, 2 for external data memory and 3 for special registers. Until a match or a halt command arrives, the core runs exactly as it would with no debugger attached.

A debug host drives a command port with four commands: run, halt, step and skip. Step lets the halted core execute one instruction. Skip tells it to move the program counter past one instruction without executing it. The host also writes breakpoint slots through a configuration port. Each slot holds an enable, a space, an access kind, an address, a data value and a data-match enable. When no slot is enabled and the core is running, the comparators are disarmed and the block reports itself idle. This lets the surrounding logic gate its clock.

Top module: `dbg_exec_ctrl`

## Requirements
- R1: After reset, `cpu_halt`, `cpu_step`, `cpu_skip`, `bp_hit` and `dbg_active` are all 0, `bp_id` is 0, and every slot is disabled.
- R2: Command codes on `cmd_op` are 0 run, 1 halt, 2 step and 3 skip, and each is taken when `cmd_valid` is high. A halt command raises `cpu_halt` in the next cycle. A run command lowers `cpu_halt` and clears `bp_hit` in the next cycle.
- R3: A step command while `cpu_halt` is high gives a one-cycle pulse on `cpu_step` in the next cycle, and `cpu_halt` stays high.
- R4: A skip command while `cpu_halt` is high gives a one-cycle pulse on `cpu_skip` in the next cycle, and `cpu_halt` stays high.
- R5: Step and skip commands issued while the core is running are ignored. Neither pulse appears and `cpu_halt` stays low.
- R6: A slot with kind 0 (program counter) matches when `pc_valid` is high and `pc` equals the slot address. Its space field is not used.
- R7: Slot kinds 1 (read), 2 (write) and 3 (read or write) match an access when `acc_valid` is high, the direction fits the kind, `acc_space` equals the slot space and `acc_addr` equals the slot address.
- R8: When a slot's data-match enable is set, an access match also needs `acc_data` to equal the slot data. When it is clear, any data value matches.
- R9: A match while running raises `cpu_halt` and sets the sticky `bp_hit` in the next cycle. `bp_id` records the lowest-numbered matching slot.
- R10: A match takes priority over a run command in the same cycle. The core halts and `bp_hit` is set.
- R11: Matches are ignored while `cpu_halt` is high. `bp_id` and `bp_hit` stay unchanged.
- R12: `dbg_active` is high exactly when at least one slot is enabled or `cpu_halt` is high.
- R13: A configuration write takes effect from the next cycle. An access in the same cycle as the write is compared against the slot's previous contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | Command code: 0 run, 1 halt, 2 step, 3 skip |
| cfg_we | input | 1 | Slot configuration write strobe |
| cfg_slot | input | SLOT_W | Slot index being written |
| cfg_en | input | 1 | Slot enable |
| cfg_space | input | 2 | Slot address space |
| cfg_kind | input | 2 | Slot kind: 0 PC, 1 read, 2 write, 3 either |
| cfg_addr | input | AW | Slot address |
| cfg_data | input | DW | Slot data value |
| cfg_dmatch | input | 1 | Slot data-match enable |
| pc_valid | input | 1 | Core is at an instruction boundary |
| pc | input | AW | Program counter at the boundary |
| acc_valid | input | 1 | Memory access present this cycle |
| acc_write | input | 1 | Access is a write (0 is a read) |
| acc_space | input | 2 | Access address space |
| acc_addr | input | AW | Access address |
| acc_data | input | DW | Data written or read |
| cpu_halt | output | 1 | Halt request to the core |
| cpu_step | output | 1 | Execute-one-instruction pulse |
| cpu_skip | output | 1 | Advance-without-execute pulse |
| bp_hit | output | 1 | Sticky breakpoint-halt flag |
| bp_id | output | SLOT_W | Slot that caused the last breakpoint halt |
| dbg_active | output | 1 | Debug logic in use (0 means power-save) |

## Verification
The hardest case to reach from the ports is a cycle where several things land together. A breakpoint match must coincide with a run command, a configuration write to the matching slot, or a second matching slot. Random addresses over a wide space would almost never collide. The stimulus therefore draws slot and access addresses from eight values and data from four values, and issues run commands often enough that the core keeps returning to the running state where matches count. Directed sequences then force the same-cycle hit-and-run case, the write-then-compare ordering and the two-slot priority case explicitly.

// File: rtl/dbg_pkg.sv
// Shared types for the debug execution controller.
// Assumes 2-bit command and kind encodings fixed by the requirements.
package dbg_pkg;
    typedef enum logic [1:0] {
        CMD_RUN  = 2'd0,
        CMD_HALT = 2'd1,
        CMD_STEP = 2'd2,
        CMD_SKIP = 2'd3
    } dbg_cmd_e;

    typedef enum logic [1:0] {
        KIND_PC  = 2'd0,
        KIND_RD  = 2'd1,
        KIND_WR  = 2'd2,
        KIND_ANY = 2'd3
    } bp_kind_e;

    typedef struct packed {
        logic       en;
        logic [1:0] space;
        bp_kind_e   kind;
        logic       dmatch;
    } bp_ctl_t;
endpackage

// File: rtl/dbg_bp_slot.sv
// One breakpoint slot: stores its condition and compares it against the
// current program counter or memory access.
// Assumes the caller drives 'armed' low while halted, so nothing toggles then.
module dbg_bp_slot
    import dbg_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  bp_ctl_t       wr_ctl,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          armed,
    input  logic          pc_valid,
    input  logic [AW-1:0] pc,
    input  logic          acc_valid,
    input  logic          acc_write,
    input  logic [1:0]    acc_space,
    input  logic [AW-1:0] acc_addr,
    input  logic [DW-1:0] acc_data,
    output logic          match,
    output logic          enabled
);
    bp_ctl_t       ctl_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] data_q;
    logic          dir_ok;
    logic          pc_hit;
    logic          acc_hit;

    // Hold the slot condition; a write lands at the clock edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q  <= '{en: 1'b0, space: 2'd0, kind: KIND_PC, dmatch: 1'b0};
            addr_q <= '0;
            data_q <= '0;
        end else if (wr_en) begin
            ctl_q  <= wr_ctl;
            addr_q <= wr_addr;
            data_q <= wr_data;
        end
    end

    // Decide whether the access direction suits the slot kind.
    always_comb begin
        unique case (ctl_q.kind)
            KIND_RD:  dir_ok = !acc_write;
            KIND_WR:  dir_ok = acc_write;
            KIND_ANY: dir_ok = 1'b1;
            default:  dir_ok = 1'b0;
        endcase
    end

    // Compare the stored condition with the live buses.
    always_comb begin
        pc_hit  = pc_valid && (pc == addr_q);
        acc_hit = acc_valid && dir_ok && (acc_space == ctl_q.space)
                  && (acc_addr == addr_q)
                  && (!ctl_q.dmatch || (acc_data == data_q));
        match   = ctl_q.en && armed &&
                  ((ctl_q.kind == KIND_PC) ? pc_hit : acc_hit);
    end

    assign enabled = ctl_q.en;
endmodule

// File: rtl/dbg_bp_prio.sv
// Lowest-index-wins encoder over the slot match lines.
// Assumes N >= 2.
module dbg_bp_prio #(
    parameter int N  = 4,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [IW-1:0] idx
);
    // Scan from the top down so the lowest set request is kept last.
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
        any = |req;
    end
endmodule

// File: rtl/dbg_exec_fsm.sv
// Run/halt control with step and skip pulses and the sticky hit flag.
// Assumes hit_any is already masked while halted; it is re-checked here.
module dbg_exec_fsm
    import dbg_pkg::*;
#(
    parameter int IW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  dbg_cmd_e      cmd,
    input  logic          hit_any,
    input  logic [IW-1:0] hit_idx,
    output logic          halt,
    output logic          step_p,
    output logic          skip_p,
    output logic          flag,
    output logic [IW-1:0] id
);
    logic          halt_q;
    logic          step_q;
    logic          skip_q;
    logic          flag_q;
    logic [IW-1:0] id_q;

    // Issue single-cycle advance pulses only from the halted state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_q <= 1'b0;
            skip_q <= 1'b0;
        end else begin
            step_q <= cmd_valid && (cmd == CMD_STEP) && halt_q;
            skip_q <= cmd_valid && (cmd == CMD_SKIP) && halt_q;
        end
    end

    // Halt state and breakpoint record; a match beats any command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            halt_q <= 1'b0;
            flag_q <= 1'b0;
            id_q   <= '0;
        end else if (hit_any && !halt_q) begin
            halt_q <= 1'b1;
            flag_q <= 1'b1;
            id_q   <= hit_idx;
        end else if (cmd_valid) begin
            case (cmd)
                CMD_RUN: begin
                    halt_q <= 1'b0;
                    flag_q <= 1'b0;
                end
                CMD_HALT: halt_q <= 1'b1;
                default:  ;
            endcase
        end
    end

    assign halt   = halt_q;
    assign step_p = step_q;
    assign skip_p = skip_q;
    assign flag   = flag_q;
    assign id     = id_q;
endmodule

// File: rtl/dbg_exec_ctrl.sv
// Top of the debug execution controller: a bank of breakpoint slots, a
// priority encoder and the run/halt state machine.
// Assumes one memory access per cycle and a PC valid only at boundaries.
module dbg_exec_ctrl
    import dbg_pkg::*;
#(
    parameter int NUM_BP = 4,
    parameter int AW     = 16,
    parameter int DW     = 8,
    localparam int SLOT_W = $clog2(NUM_BP)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic              cfg_we,
    input  logic [SLOT_W-1:0] cfg_slot,
    input  logic              cfg_en,
    input  logic [1:0]        cfg_space,
    input  logic [1:0]        cfg_kind,
    input  logic [AW-1:0]     cfg_addr,
    input  logic [DW-1:0]     cfg_data,
    input  logic              cfg_dmatch,
    input  logic              pc_valid,
    input  logic [AW-1:0]     pc,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [1:0]        acc_space,
    input  logic [AW-1:0]     acc_addr,
    input  logic [DW-1:0]     acc_data,
    output logic              cpu_halt,
    output logic              cpu_step,
    output logic              cpu_skip,
    output logic              bp_hit,
    output logic [SLOT_W-1:0] bp_id,
    output logic              dbg_active
);
    logic [NUM_BP-1:0] slot_match;
    logic [NUM_BP-1:0] slot_en;
    logic              any_hit;
    logic [SLOT_W-1:0] hit_idx;
    logic              halt_w;
    bp_ctl_t           new_ctl;

    // Pack the configuration fields for the slot bank.
    always_comb begin
        new_ctl = '{en: cfg_en, space: cfg_space,
                    kind: bp_kind_e'(cfg_kind), dmatch: cfg_dmatch};
    end

    for (genvar g = 0; g < NUM_BP; g++) begin : g_slot
        dbg_bp_slot #(.AW(AW), .DW(DW)) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en     (cfg_we && (cfg_slot == SLOT_W'(g))),
            .wr_ctl    (new_ctl),
            .wr_addr   (cfg_addr),
            .wr_data   (cfg_data),
            .armed     (!halt_w),
            .pc_valid  (pc_valid),
            .pc        (pc),
            .acc_valid (acc_valid),
            .acc_write (acc_write),
            .acc_space (acc_space),
            .acc_addr  (acc_addr),
            .acc_data  (acc_data),
            .match     (slot_match[g]),
            .enabled   (slot_en[g])
        );
    end

    dbg_bp_prio #(.N(NUM_BP), .IW(SLOT_W)) u_prio (
        .req (slot_match),
        .any (any_hit),
        .idx (hit_idx)
    );

    dbg_exec_fsm #(.IW(SLOT_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd       (dbg_cmd_e'(cmd_op)),
        .hit_any   (any_hit),
        .hit_idx   (hit_idx),
        .halt      (halt_w),
        .step_p    (cpu_step),
        .skip_p    (cpu_skip),
        .flag      (bp_hit),
        .id        (bp_id)
    );

    assign cpu_halt   = halt_w;
    assign dbg_active = (|slot_en) || halt_w;
endmodule

// File: rtl/dbg_exec_ctrl_chk.sv
// Port-level property checker for dbg_exec_ctrl, attached by bind.
module dbg_exec_ctrl_chk #(
    parameter int SLOT_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic [1:0]        cmd_op,
    input logic              cpu_halt,
    input logic              cpu_step,
    input logic              cpu_skip,
    input logic              bp_hit,
    input logic [SLOT_W-1:0] bp_id,
    input logic              dbg_active
);
    assert_halt_cmd_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 2'd1) |=> cpu_halt);

    assert_flag_clear_by_run_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bp_hit) |-> $past(cmd_valid && cmd_op == 2'd0));

    assert_step_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 2'd2 && cpu_halt) |=> (cpu_step && cpu_halt));

    assert_skip_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 2'd3 && cpu_halt) |=> (cpu_skip && cpu_halt));

    assert_no_advance_running_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_step || cpu_skip) |-> $past(cpu_halt));

    assert_hit_halts_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bp_hit) |-> cpu_halt);

    assert_id_frozen_halted_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_halt && $past(cpu_halt)) |-> $stable(bp_id));

    assert_active_when_halted_R12: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_halt |-> dbg_active);
endmodule

bind dbg_exec_ctrl dbg_exec_ctrl_chk #(.SLOT_W(SLOT_W)) u_chk (.*);

// File: tb/dbg_exec_ctrl_test.sv
// Self-checking bench: directed corners plus seeded random traffic,
// compared each cycle against a behavioural model.
module dbg_exec_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int NB = 4;
    localparam int AW = 16;
    localparam int DW = 8;
    localparam int SW = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_valid = 0; logic [1:0] cmd_op = 0;
    logic cfg_we = 0; logic [SW-1:0] cfg_slot = 0; logic cfg_en = 0;
    logic [1:0] cfg_space = 0, cfg_kind = 0; logic [AW-1:0] cfg_addr = 0;
    logic [DW-1:0] cfg_data = 0; logic cfg_dmatch = 0;
    logic pc_valid = 0; logic [AW-1:0] pc = 0;
    logic acc_valid = 0, acc_write = 0; logic [1:0] acc_space = 0;
    logic [AW-1:0] acc_addr = 0; logic [DW-1:0] acc_data = 0;
    logic cpu_halt, cpu_step, cpu_skip, bp_hit, dbg_active;
    logic [SW-1:0] bp_id;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Model state
    bit m_en[NB]; bit [1:0] m_sp[NB]; bit [1:0] m_kd[NB];
    bit [AW-1:0] m_ad[NB]; bit [DW-1:0] m_dt[NB]; bit m_dm[NB];
    bit e_halt, e_step, e_skip, e_flag; bit [SW-1:0] e_id;

    dbg_exec_ctrl #(.NUM_BP(NB), .AW(AW), .DW(DW)) uut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic bit slot_hit(int i);
        bit dir;
        if (!m_en[i]) return 0;
        if (m_kd[i] == 2'd0) return pc_valid && pc == m_ad[i];
        dir = (m_kd[i] == 2'd3) || (m_kd[i] == 2'd1 && !acc_write) ||
              (m_kd[i] == 2'd2 && acc_write);
        return acc_valid && dir && acc_space == m_sp[i] && acc_addr == m_ad[i]
               && (!m_dm[i] || acc_data == m_dt[i]);
    endfunction

    function automatic bit any_en();
        for (int i = 0; i < NB; i++) if (m_en[i]) return 1;
        return 0;
    endfunction

    // Advance the model by one edge using the inputs held during it.
    task automatic tick(string tag);
        bit hit; int hid;
        @(posedge clk);
        hit = 0; hid = 0;
        if (!e_halt)
            for (int i = NB - 1; i >= 0; i--) if (slot_hit(i)) begin hit = 1; hid = i; end
        e_step = cmd_valid && cmd_op == 2'd2 && e_halt;
        e_skip = cmd_valid && cmd_op == 2'd3 && e_halt;
        if (hit) begin e_halt = 1; e_flag = 1; e_id = SW'(hid); end
        else if (cmd_valid && cmd_op == 2'd0) begin e_halt = 0; e_flag = 0; end
        else if (cmd_valid && cmd_op == 2'd1) e_halt = 1;
        if (cfg_we) begin
            m_en[cfg_slot] = cfg_en; m_sp[cfg_slot] = cfg_space; m_kd[cfg_slot] = cfg_kind;
            m_ad[cfg_slot] = cfg_addr; m_dt[cfg_slot] = cfg_data; m_dm[cfg_slot] = cfg_dmatch;
        end
        #1;
        check({tag, " halt"}, cpu_halt, e_halt);
        check({tag, " step"}, cpu_step, e_step);
        check({tag, " skip"}, cpu_skip, e_skip);
        check({tag, " flag"}, bp_hit, e_flag);
        check({tag, " id"}, bp_id, e_id);
        check({tag, " R12 active"}, dbg_active, any_en() || e_halt);
    endtask

    task automatic idle();
        @(negedge clk);
        cmd_valid = 0; cfg_we = 0; pc_valid = 0; acc_valid = 0;
    endtask

    task automatic cfg(int s, bit en, int sp, int kd, int ad, int dt, bit dm);
        cfg_we = 1; cfg_slot = SW'(s); cfg_en = en; cfg_space = 2'(sp);
        cfg_kind = 2'(kd); cfg_addr = AW'(ad); cfg_data = DW'(dt); cfg_dmatch = dm;
    endtask

    task automatic cmd(int op);
        cmd_valid = 1; cmd_op = 2'(op);
    endtask

    task automatic acc(bit wr, int sp, int ad, int dt);
        acc_valid = 1; acc_write = wr; acc_space = 2'(sp);
        acc_addr = AW'(ad); acc_data = DW'(dt);
    endtask

    initial begin
        for (int i = 0; i < NB; i++) begin
            m_en[i] = 0; m_sp[i] = 0; m_kd[i] = 0; m_ad[i] = 0; m_dt[i] = 0; m_dm[i] = 0;
        end
        e_halt = 0; e_step = 0; e_skip = 0; e_flag = 0; e_id = 0;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        #1;
        // R1: reset state
        check("R1 halt", cpu_halt, 0); check("R1 step", cpu_step, 0);
        check("R1 skip", cpu_skip, 0); check("R1 flag", bp_hit, 0);
        check("R1 id", bp_id, 0); check("R1 active", dbg_active, 0);

        // R5: step/skip while running are ignored
        idle(); cmd(2); tick("R5 step-running");
        idle(); cmd(3); tick("R5 skip-running");
        // R2/R3/R4: halt, step, skip, run
        idle(); cmd(1); tick("R2 halt-cmd");
        idle(); cmd(2); tick("R3 step");
        idle(); tick("R3 step-ends");
        idle(); cmd(3); tick("R4 skip");
        idle(); cmd(0); tick("R2 run-cmd");
        // R6: PC slot, space field ignored
        idle(); cfg(0, 1, 3, 0, 'h40, 0, 0); tick("R13 cfg-pc");
        idle(); pc_valid = 1; pc = 'h41; tick("R6 pc-miss");
        idle(); pc_valid = 1; pc = 'h40; tick("R6 R9 pc-hit");
        // R11: matches ignored while halted
        idle(); pc_valid = 1; pc = 'h40; tick("R11 halted-hit");
        idle(); cmd(0); tick("R2 run-clears");
        // R7/R8: write slot with data match; priority across slots
        idle(); cfg(0, 0, 0, 0, 0, 0, 0); tick("cfg-off");
        idle(); cfg(2, 1, 1, 2, 'h12, 'h5A, 1); tick("cfg2");
        idle(); cfg(1, 1, 1, 3, 'h12, 0, 0); tick("cfg1");
        idle(); acc(1, 1, 'h12, 'h5A); tick("R9 prio-lowest");
        idle(); cmd(0); tick("run");
        idle(); cfg(1, 0, 0, 0, 0, 0, 0); tick("cfg1-off");
        idle(); acc(1, 1, 'h12, 'h11); tick("R8 data-miss");
        idle(); acc(0, 1, 'h12, 'h5A); tick("R7 dir-miss");
        idle(); acc(1, 2, 'h12, 'h5A); tick("R7 space-miss");
        // R10: hit beats run in same cycle
        idle(); acc(1, 1, 'h12, 'h5A); cmd(0); tick("R10 hit-vs-run");
        idle(); cmd(0); tick("run");
        // R13: write and access same cycle compare against old contents
        idle(); cfg(3, 1, 2, 1, 'h77, 0, 0); acc(0, 2, 'h77, 0); tick("R13 same-cycle");
        idle(); acc(0, 2, 'h77, 0); tick("R13 next-cycle");
        idle(); cmd(0); tick("run");

        // Random traffic
        for (int n = 0; n < 3000; n++) begin
            int r;
            idle();
            r = $urandom_range(0, 99);
            if (r < 8) cfg($urandom_range(0, NB-1), $urandom_range(0, 3) != 0,
                           $urandom_range(0, 3), $urandom_range(0, 3),
                           $urandom_range(0, 7), $urandom_range(0, 3), $urandom_range(0, 1));
            r = $urandom_range(0, 99);
            if (r < 12) cmd(0);
            else if (r < 15) cmd(1);
            else if (r < 20) cmd(2);
            else if (r < 25) cmd(3);
            if ($urandom_range(0, 1)) begin pc_valid = 1; pc = AW'($urandom_range(0, 7)); end
            if ($urandom_range(0, 1))
                acc($urandom_range(0, 1), $urandom_range(0, 3), $urandom_range(0, 7),
                    $urandom_range(0, 3));
            tick("R7 R8 R9 random");
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule